// File: doc/BRIEF.md
# Six-Stage CIC Interpolator With Selectable Decade Ratio

This block raises the sample rate of one signed 16-bit stream with a sixth-order cascaded integrator-comb filter. A 3-bit select code picks one of five rate changes (5, 50, 500, 5000, 50000) or a bypass. Each accepted low-rate sample runs once through six comb stages. The filter then steps six integrators once per high-rate output slot, and zero-stuffing feeds the comb result into the first slot of each burst only. The downstream side paces the output: it raises an output-enable strobe on each clock where it can take a sample.

The integrator result is scaled down by a fixed power of two for each ratio. This keeps the gain at or below one. The remaining ratio-dependent gain error is left for downstream correction. A hold input clears all filter state and is the only point, apart from reset, where a new select code is taken. Integrator arithmetic wraps in two's complement.

Top module: `cic_interp6`

## Requirements
- R1: With the latched select code 1, 2, 3, 6 or 7, each accepted input sample yields exactly 5, 50, 500, 5000 or 50000 output samples respectively.
- R2: With the latched select code 0, 4 or 5 (bypass), `out_valid` and `out_data` equal `in_valid` and `in_data` one clock later, and `in_ready` is high unless `hold` is high.
- R3: In filter mode, one output sample is produced for each clock with `out_en` high while a burst is pending. It appears with `out_valid` high one clock later. No output appears otherwise.
- R4: In filter mode, `in_ready` is low from the clock after an accepted sample until its burst has been fully emitted. `in_valid` is ignored while `in_ready` is low.
- R5: For a constant input x held long enough, the settled output equals floor(x·R^5 / 2^S), with S = 12, 29, 45, 62, 79 for R = 5, 50, 500, 5000, 50000.
- R6: While `hold` is high, `in_ready` is low, `out_valid` is low from the next clock on, and all comb, integrator and burst-counter state is cleared. After release, no stale output is emitted, and a zero input yields only zero outputs.
- R7: `rate_sel` is sampled only during a clock with `rst` or `hold` high. Changes at other times have no effect on the ratio.
- R8: `rst` is synchronous. On the clock after it is sampled high, `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Suspend: clears filter state and loads the select code |
| rate_sel | input | 3 | Ratio select code |
| in_data | input | DW | Signed low-rate input sample |
| in_valid | input | 1 | Input sample strobe |
| out_en | input | 1 | High-rate output slot strobe |
| in_ready | output | 1 | Block can accept an input sample |
| out_data | output | DW | Signed high-rate output sample |
| out_valid | output | 1 | Output sample strobe |

## Verification
The bench builds the block with its defaults: DW = 16 and RMAX = 50000. This gives a 112-bit internal path, so every ratio, including the 50000 burst, is exercised at its real length. A table of constant-input runs covers ratios 5 through 5000 with positive and negative levels and with a gated output strobe. It checks both the output count and the settled value. Directed tests cover the full 50000 burst count, bypass codes, hold mid-burst, ignored inputs while busy, and a select change without clearing.

// File: rtl/cic_interp6.sv
module cic_interp6 #(
  parameter int DW   = 16,
  parameter int RMAX = 50000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hold,
  input  logic [2:0]           rate_sel,
  input  logic signed [DW-1:0] in_data,
  input  logic                 in_valid,
  input  logic                 out_en,
  output logic                 in_ready,
  output logic signed [DW-1:0] out_data,
  output logic                 out_valid
);
  localparam int NST = 6;
  localparam int W   = DW + NST * $clog2(RMAX);
  localparam int CW  = $clog2(RMAX + 1);

  function automatic int ratio_of(input logic [2:0] s);
    case (s)
      3'd1: return 5;
      3'd2: return 50;
      3'd3: return 500;
      3'd6: return 5000;
      3'd7: return 50000;
      default: return 0;
    endcase
  endfunction

  function automatic int shift_of(input logic [2:0] s);
    case (s)
      3'd1: return 12;
      3'd2: return 29;
      3'd3: return 45;
      3'd6: return 62;
      3'd7: return 79;
      default: return 0;
    endcase
  endfunction

  logic [2:0]          sel_q;
  logic                byp;
  logic [CW-1:0]       cnt;
  logic                first;
  logic signed [W-1:0] cmb;
  logic signed [W-1:0] cdl [NST];
  logic signed [W-1:0] cv  [NST+1];
  logic signed [W-1:0] acc [NST];
  logic signed [DW-1:0] out_q;
  logic                accept, step;

  assign byp      = (ratio_of(sel_q) == 0);
  assign in_ready = ~hold & (byp | (cnt == '0));
  assign accept   = in_valid & in_ready & ~byp;
  assign step     = out_en & ~hold & (cnt != '0);
  assign out_data = byp ? out_q : DW'(acc[NST-1] >>> shift_of(sel_q));

  always_comb begin
    cv[0] = {{(W-DW){in_data[DW-1]}}, in_data};
    for (int k = 0; k < NST; k++) cv[k+1] = cv[k] - cdl[k];
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      sel_q     <= rate_sel;
      cnt       <= '0;
      first     <= 1'b0;
      cmb       <= '0;
      out_q     <= '0;
      out_valid <= 1'b0;
      for (int k = 0; k < NST; k++) begin
        cdl[k] <= '0;
        acc[k] <= '0;
      end
    end else begin
      out_valid <= byp ? in_valid : step;
      if (byp) out_q <= in_data;
      if (accept) begin
        for (int k = 0; k < NST; k++) cdl[k] <= cv[k];
        cmb   <= cv[NST];
        cnt   <= CW'(ratio_of(sel_q));
        first <= 1'b1;
      end
      if (step) begin
        cnt    <= cnt - 1'b1;
        first  <= 1'b0;
        acc[0] <= acc[0] + (first ? cmb : '0);
        for (int k = 1; k < NST; k++) acc[k] <= acc[k] + acc[k-1];
      end
    end
  end
endmodule

// File: rtl/cic_interp6_chk.sv
module cic_interp6_chk (
  input logic       clk,
  input logic       rst,
  input logic       hold,
  input logic       out_en,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic [15:0] out_data,
  input logic       byp,
  input logic [2:0] sel_q
);
  // R3
  out_slot_chk: assert property (@(posedge clk) disable iff (rst || hold)
    (out_valid && !byp) |-> $past(out_en));
  // R4
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst || hold)
    (in_valid && in_ready && !byp) |=> !in_ready);
  // R6
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> !out_valid);
  // R6
  hold_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> !in_ready);
  // R7
  sel_stable_chk: assert property (@(posedge clk) disable iff (rst || hold)
    1'b1 |=> $stable(sel_q));
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == 16'd0));
endmodule

bind cic_interp6 cic_interp6_chk u_chk (
  .clk(clk), .rst(rst), .hold(hold), .out_en(out_en), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .byp(byp), .sel_q(sel_q)
);

// File: tb/cic_interp6_bench.sv
module cic_interp6_bench;
  localparam int CLK_NS = 10;
  localparam int NV = 6;
  localparam int V_SEL [NV] = '{1, 1, 2, 3, 6, 1};
  localparam int V_X   [NV] = '{1000, -1000, 1000, 1000, 1000, 20000};
  localparam int V_R   [NV] = '{5, 5, 50, 500, 5000, 5};
  localparam int V_EXP [NV] = '{762, -763, 582, 888, 677, 15258};
  localparam int V_GATE[NV] = '{0, 1, 0, 0, 0, 0};

  logic clk = 0, rst = 1, hold = 0, in_valid = 0, out_en = 1;
  logic [2:0] rate_sel = 0;
  logic signed [15:0] in_data = 0;
  logic in_ready, out_valid;
  logic signed [15:0] out_data;

  int checks = 0, failures = 0, ocount = 0, nonzero = 0, cycles = 0;
  int gate = 0;
  logic signed [15:0] last = 0;
  bit done = 0;

  cic_interp6 u_cic_interp6 (.clk(clk), .rst(rst), .hold(hold), .rate_sel(rate_sel),
    .in_data(in_data), .in_valid(in_valid), .out_en(out_en), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid));

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (out_valid) begin
      ocount++;
      last = out_data;
      if (out_data != 0) nonzero++;
    end
    out_en <= gate ? ~out_en : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_sel(input int s);
    @(negedge clk);
    rate_sel = 3'(s);
    hold = 1;
    @(negedge clk);
    hold = 0;
  endtask

  task automatic feed(input int x);
    while (!in_ready) @(negedge clk);
    in_data = 16'(x);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R8 out_valid", out_valid, 0);
    chk(out_data == 0, "R8 out_data", out_data, 0);
    rst = 0;
    @(negedge clk);
    chk(in_ready == 1, "R2 ready after reset", in_ready, 1);

    for (int v = 0; v < NV; v++) begin
      set_sel(V_SEL[v]);
      gate = V_GATE[v];
      ocount = 0;
      for (int i = 0; i < 8; i++) feed(V_X[v]);
      drain();
      chk(ocount == 8 * V_R[v], "R1 R3 output count", ocount, 8 * V_R[v]);
      chk(last == V_EXP[v], "R5 settled value", last, V_EXP[v]);
    end
    gate = 0;

    set_sel(7);
    ocount = 0;
    feed(1000);
    chk(in_ready == 0, "R4 busy after accept", in_ready, 0);
    drain();
    chk(ocount == 50000, "R1 ratio 50000 count", ocount, 50000);

    set_sel(1);
    rate_sel = 3'd2;
    ocount = 0;
    feed(300);
    in_valid = 1;
    in_data = 16'sd5000;
    repeat (3) @(negedge clk);
    in_valid = 0;
    drain();
    chk(ocount == 5, "R4 R7 ignored input and stale select", ocount, 5);

    set_sel(1);
    feed(1000);
    repeat (2) @(negedge clk);
    hold = 1;
    @(negedge clk);
    chk(out_valid == 0, "R6 out_valid in hold", out_valid, 0);
    chk(in_ready == 0, "R6 in_ready in hold", in_ready, 0);
    hold = 0;
    ocount = 0;
    repeat (10) @(negedge clk);
    chk(ocount == 0, "R6 no stale burst", ocount, 0);
    nonzero = 0;
    feed(0);
    drain();
    chk(ocount == 5, "R6 count after clear", ocount, 5);
    chk(nonzero == 0, "R6 zero output after clear", nonzero, 0);

    for (int s = 0; s < 6; s++) begin
      if (s == 0 || s == 4 || s == 5) begin
        set_sel(s);
        in_data = 16'(-1234 + s);
        in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        chk(in_ready == 1, "R2 bypass ready", in_ready, 1);
        chk(out_valid == 1, "R2 bypass valid", out_valid, 1);
        chk(out_data == 16'(-1234 + s), "R2 bypass data", out_data, -1234 + s);
        @(negedge clk);
        chk(out_valid == 0, "R2 bypass valid drop", out_valid, 0);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule